// File: doc/BRIEF.md
# Packed Colour Lookup Table with Format Converter

The block holds a 256-entry colour lookup table in 128 storage words of 32 bits. Each word holds two 15-bit colour entries, one in each half, and each entry carries a spare top bit. A bus side writes and reads whole words. A lookup side presents an 8-bit pixel index and a 2-bit format code. One cycle later it receives that entry, widened to 8 bits per component and then packed into the chosen output format.

Only the raw words are stored. The conversion is done on the lookup path, so a change of output format takes effect on the next lookup and needs no rewrite of the table. A display pipeline uses the block by loading the table over the bus once. It then streams pixel indices into the lookup port.

Top module: `clut_packed`

## Requirements
- R1: After reset every storage word is zero, `rd_word` is zero, `px_out_vld` is 0 and `px_color` is zero.
- R2: Storage word w holds entry 2w in bits [15:0] and entry 2w+1 in bits [31:16]. The lookup index selects word `px_index[7:1]`, and `px_index[0]` picks the half.
- R3: In a stored entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 has no effect on any lookup result.
- R4: With `px_fmt` = 2, `px_color` = {8'h0, r5, g5, 1'b0, b5}. This is 16-bit 5-6-5, with each component first widened to 8 bits by appending three zero bits.
- R5: With `px_fmt` = 1, `px_color` = {9'h0, r5, g5, b5}. This is 15-bit 5-5-5.
- R6: With `px_fmt` = 0, `px_color` = {16'h0, r5[4:2], g5[4:2], b5[4:3]}. This is 8-bit 3-3-2.
- R7: With `px_fmt` = 3, `px_color` = {r5, 3'b0, g5, 3'b0, b5, 3'b0}. This is 24-bit 8-8-8.
- R8: A lookup presented with `px_req` = 1 at clock edge k appears on `px_color` after edge k, together with `px_out_vld` = 1. `px_out_vld` follows `px_req` with exactly one cycle of delay.
- R9: A lookup at the same edge as a bus write to the word that holds the entry returns the contents from before that write.
- R10: `rd_word` shows the word at `bus_addr` one cycle after that address is presented. At an edge where the same word is also written, it shows the data from before the write.
- R11: At an edge with `px_req` = 0, `px_color` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write the word at `bus_addr` |
| bus_addr | input | 7 | Word address for write and readback |
| bus_wdata | input | 32 | Write data: two packed entries |
| rd_word | output | 32 | Registered readback of the addressed word |
| px_req | input | 1 | Lookup request |
| px_index | input | 8 | Entry index for lookup |
| px_fmt | input | 2 | Output format: 0=3-3-2, 1=5-5-5, 2=5-6-5, 3=8-8-8 |
| px_out_vld | output | 1 | Lookup result valid |
| px_color | output | 24 | Converted colour, right-aligned and zero-filled |

## Verification
A bus write and a lookup can hit the same storage word at the same edge. A bus write and a readback of the same address can also meet at one edge. Both collisions are provoked in a random phase that confines bus addresses and lookup indices to a few neighbouring words, so they meet often. A directed collision is added on top of that. The reference model in the bench takes its lookup and readback results from its own table before that edge's write is applied, so any result that shows the new data is reported as a mismatch.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int ENTRY_W = 16;
    localparam int COMP_W  = 5;
    localparam int COLOR_W = 24;

    typedef enum logic [1:0] {
        FMT_332 = 2'd0,
        FMT_555 = 2'd1,
        FMT_565 = 2'd2,
        FMT_888 = 2'd3
    } px_fmt_e;
endpackage

// File: rtl/clut_store.sv
module clut_store #(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R10
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/clut_convert.sv
module clut_convert
    import clut_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  px_fmt_e            fmt,
    output logic [COLOR_W-1:0] color
);
    logic [COMP_W-1:0] r5, g5, b5;
    logic [7:0] r8, g8, b8;

    always_comb begin
        r5 = entry[4:0];
        g5 = entry[9:5];
        b5 = entry[14:10];
        r8 = {r5, 3'b000};
        g8 = {g5, 3'b000};
        b8 = {b5, 3'b000};
        unique case (fmt)
            FMT_332: color = {16'h0, r8[7:5], g8[7:5], b8[7:6]};
            FMT_555: color = {9'h0, r8[7:3], g8[7:3], b8[7:3]};
            FMT_565: color = {8'h0, r8[7:3], g8[7:2], b8[7:3]};
            FMT_888: color = {r8, g8, b8};
            default: color = '0;
        endcase
    end

    // R6
    always_comb begin
        narrow_332_chk: assert (fmt != FMT_332 || color[23:8] == 16'h0);
    end
    // R7
    always_comb begin
        low_zero_888_chk: assert (fmt != FMT_888 || (color[2:0] == 3'b0 && color[10:8] == 3'b0));
    end
endmodule

// File: rtl/clut_packed.sv
module clut_packed
    import clut_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_word,
    input  logic              px_req,
    input  logic [ADDR_W:0]   px_index,
    input  logic [1:0]        px_fmt,
    output logic              px_out_vld,
    output logic [23:0]       px_color
);
    localparam int WORD_W = 2 * ENTRY_W;

    logic [WORD_W-1:0]  bus_word, px_word;
    logic [ENTRY_W-1:0] px_entry;
    logic [COLOR_W-1:0] conv_color;

    clut_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_wr),
        .waddr   (bus_addr),
        .wdata   (bus_wdata),
        .raddr_a (bus_addr),
        .rdata_a (bus_word),
        .raddr_b (px_index[ADDR_W:1]),
        .rdata_b (px_word)
    );

    assign px_entry = px_index[0] ? px_word[WORD_W-1:ENTRY_W] : px_word[ENTRY_W-1:0];

    clut_convert u_conv (
        .entry (px_entry),
        .fmt   (px_fmt_e'(px_fmt)),
        .color (conv_color)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word    <= '0;
            px_out_vld <= 1'b0;
            px_color   <= '0;
        end else begin
            rd_word    <= bus_word;
            px_out_vld <= px_req;
            if (px_req) px_color <= conv_color;
        end
    end

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_req |=> px_out_vld);
    // R8
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_req |=> !px_out_vld);
    // R11
    color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_req |=> $stable(px_color));
    // R10
    rd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !$past(bus_wr) && $stable(bus_addr)) |=> $stable(rd_word));
endmodule

// File: tb/test_clut_packed.sv
module test_clut_packed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_word;
    logic        px_req = 1'b0;
    logic [7:0]  px_index = '0;
    logic [1:0]  px_fmt = '0;
    logic        px_out_vld;
    logic [23:0] px_color;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    logic [31:0] ref_mem [128];
    logic [31:0] exp_rd = '0;
    logic        exp_vld = 1'b0;
    logic [23:0] exp_col = '0;
    logic [1:0]  exp_fmt = '0;

    always #10 clk = ~clk;

    clut_packed i_clut_packed (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_word(rd_word), .px_req(px_req),
        .px_index(px_index), .px_fmt(px_fmt), .px_out_vld(px_out_vld),
        .px_color(px_color)
    );

    function automatic logic [23:0] model_conv(input logic [15:0] e, input logic [1:0] f);
        int r, g, b;
        r = (int'(e) & 31) << 3;
        g = ((int'(e) >> 5) & 31) << 3;
        b = ((int'(e) >> 10) & 31) << 3;
        case (f)
            2'd0: return 24'(((r >> 5) << 5) | ((g >> 5) << 2) | (b >> 6));
            2'd1: return 24'(((r >> 3) << 10) | ((g >> 3) << 5) | (b >> 3));
            2'd2: return 24'(((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3));
            default: return 24'((r << 16) | (g << 8) | b);
        endcase
    endfunction

    function automatic string fmt_tag(input logic [1:0] f);
        case (f)
            2'd0: return "R6";
            2'd1: return "R5";
            2'd2: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: results come from the table before this edge's write (R9, R10)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) ref_mem[i] = '0;
            exp_rd = '0; exp_vld = 1'b0; exp_col = '0;
        end else begin
            logic [31:0] w;
            exp_rd = ref_mem[bus_addr];
            exp_vld = px_req;
            if (px_req) begin
                w = ref_mem[px_index >> 1];
                exp_col = model_conv(px_index[0] ? w[31:16] : w[15:0], px_fmt);
                exp_fmt = px_fmt;
            end
            if (bus_wr) ref_mem[bus_addr] = bus_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R10 readback", rd_word, exp_rd);
            check("R8 valid", {31'b0, px_out_vld}, {31'b0, exp_vld});
            check({fmt_tag(exp_fmt), "/R2/R9/R11 colour"}, {8'h0, px_color}, {8'h0, exp_col});
        end
    end

    task automatic idle();
        bus_wr = 0; px_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 50000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_word", rd_word, 32'h0);
        check("R1 valid", {31'b0, px_out_vld}, 32'h0);
        check("R1 colour", {8'h0, px_color}, 32'h0);
        cmp_on = 1;

        // directed: word 5 = {0x1234, 0xABCD}; entry 10 = 0xABCD, bit 15 set (R3)
        bus_wr = 1; bus_addr = 7'd5; bus_wdata = 32'h1234_ABCD;
        @(negedge clk);
        idle();
        px_req = 1; px_index = 8'd10; px_fmt = 2'd2;
        @(negedge clk);
        idle();
        check("R4/R3 directed 565", {8'h0, px_color}, 32'h0000_6F8A);
        px_req = 1; px_index = 8'd10; px_fmt = 2'd3;
        @(negedge clk);
        idle();
        check("R7 directed 888", {8'h0, px_color}, 32'h0068_F050);
        // R3: same entry with bit 15 cleared gives same 888 result
        bus_wr = 1; bus_addr = 7'd5; bus_wdata = 32'h1234_2BCD;
        @(negedge clk);
        idle();
        px_req = 1; px_index = 8'd10; px_fmt = 2'd3;
        @(negedge clk);
        idle();
        check("R3 bit15 ignored", {8'h0, px_color}, 32'h0068_F050);
        // R9: directed collision, write word 5 while looking up entry 11
        bus_wr = 1; bus_addr = 7'd5; bus_wdata = 32'hFFFF_FFFF;
        px_req = 1; px_index = 8'd11; px_fmt = 2'd1;
        @(negedge clk);
        idle();
        check("R9 old data", {8'h0, px_color}, {8'h0, model_conv(16'h1234, 2'd1)});
        check("R10 old readback", rd_word, 32'h1234_2BCD);
        @(negedge clk);
        // R11: idle cycles keep colour
        check("R11 hold", {8'h0, px_color}, {8'h0, model_conv(16'h1234, 2'd1)});

        // random phase with narrow address window to force collisions
        for (int k = 0; k < 4000; k++) begin
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 7'(k < 2000 ? ($urandom % 4) : $urandom);
            bus_wdata = $urandom;
            px_req    = ($urandom % 4) != 0;
            px_index  = 8'(k < 2000 ? ($urandom % 8) : $urandom);
            px_fmt    = 2'($urandom);
            @(negedge clk);
        end
        idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule